// File: doc/BRIEF.md
# Packed Byte Data Buffer

This block is a four-byte staging buffer that sits between a 16-bit processor data register and a byte-serial shift engine. The processor side moves data in pairs of bytes: each write delivers two bytes for transmission, and each read takes two received bytes. The serial side works one byte at a time: it pops the next byte to send and pushes each byte it receives. All bytes live in one 32-bit word. Separate fill counts track the transmit and receive bytes held in that word.

A byte-order input chooses how the two bytes of a register access map onto the low two byte lanes of the word. Instead of holding sticky flags, the buffer reports its conditions as one-cycle event strobes: transmit underflow and its clearing, transmit-ready and its clearing, receive overflow and its clearing, receive-ready, and single-leftover-byte. A status or interrupt block further up collects these strobes.

Each cycle carries out at most one operation. The four request strobes are ranked by a fixed priority. Data outputs are combinational views of the current word, valid in the cycle the matching strobe is raised. Each operation takes effect at the next rising clock edge.

Top module: `pbb_buffer`

## Requirements
- R1: After reset both fill counts are 0 and the word is all zero, so `rd_data` and `tx_byte` read 0.
- R2: A write accepted while `tx_count` is at most 2 shifts the word left by 16 bits, places the new pair in bits 15:0, adds 2 to `tx_count`, and pulses `ev_tx_under_clr`. It also pulses `ev_tx_ready_clr` when the new `tx_count` is 3 or 4.
- R3: A write made while `tx_count` is above 2 is refused. Word and counts stay unchanged and no event pulses.
- R4: Write byte order. With `big_endian`=1, word bits 15:0 take `wr_data` as given. With `big_endian`=0, word bits 15:8 take `wr_data[7:0]` and bits 7:0 take `wr_data[15:8]`.
- R5: A transmit pop with `tx_count`>0 presents byte lane `tx_count-1` on `tx_byte` (lane k is word bits 8k+7:8k), decrements `tx_count` and pulses `ev_tx_ready`. When no pop is requested, `tx_byte` shows that same lane.
- R6: A transmit pop with `tx_count`=0 presents 0 on `tx_byte`, pulses `ev_tx_under` and `ev_tx_ready`, and leaves `tx_count` at 0.
- R7: A receive push with `rx_count`<4 ORs `rx_byte` into lane `rx_count`, increments `rx_count` and pulses `ev_rx_ready`.
- R8: A receive push with `rx_count`=4 drops the byte, pulses `ev_rx_over` and `ev_rx_ready`, and leaves word and count unchanged.
- R9: Read data. With `big_endian`=1, `rd_data` = {word[7:0], word[15:8]}. With `big_endian`=0, `rd_data` = word[15:0].
- R10: A read with `rx_count`=1 pulses `ev_rx_single` and sets `rx_count` to 0, leaving the word unchanged.
- R11: A read with `rx_count` of 2 or more subtracts 2 from the count. When the count was 3 or 4, it also shifts the word right by 16 bits with zero fill. A read with `rx_count`=0 changes neither word nor count.
- R12: Every read, whatever the count, pulses `ev_rx_over_clr`.
- R13: When several request strobes are high together, only one acts, in the order write, read, transmit pop, receive push. The others have no effect and raise no events. A refused write still takes the cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| big_endian | input | 1 | Byte-order select for register accesses |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 16 | Register write pair |
| rd_en | input | 1 | Register read strobe |
| rd_data | output | 16 | Register read pair (combinational) |
| tx_req | input | 1 | Engine transmit pop strobe |
| tx_byte | output | 8 | Byte offered to the engine (combinational) |
| rx_push | input | 1 | Engine receive push strobe |
| rx_byte | input | 8 | Byte received by the engine |
| tx_count | output | 3 | Transmit bytes held |
| rx_count | output | 3 | Receive bytes held |
| ev_tx_under | output | 1 | Transmit underflow event |
| ev_tx_under_clr | output | 1 | Transmit underflow cleared |
| ev_tx_ready | output | 1 | Transmit ready event |
| ev_tx_ready_clr | output | 1 | Transmit ready cleared |
| ev_rx_over | output | 1 | Receive overflow event |
| ev_rx_over_clr | output | 1 | Receive overflow cleared |
| ev_rx_ready | output | 1 | Receive ready event |
| ev_rx_single | output | 1 | Single leftover byte read |

## Verification
The assertions check on every cycle that:
- both counts stay in range;
- a refused write leaves the counts alone, and an accepted one adds exactly two;
- an empty pop yields zero with the underflow event;
- a full push keeps `rx_count` at four;
- a one-byte read raises the single-byte event and empties the count;
- every read clears overflow;
- a write beside a read suppresses the read.

Only the bench's scenarios can show the byte contents: which lane each pop returns, how pushed bytes OR into place, and how the two byte-order settings map pairs in each direction. These follow from long mixed sequences whose expected word the bench tracks on its own.

// File: rtl/pbb_pkg.sv
package pbb_pkg;

  // Operation granted in the current cycle.
  typedef enum logic [2:0] {
    OP_IDLE   = 3'd0,
    OP_WR     = 3'd1,
    OP_RD     = 3'd2,
    OP_TXPOP  = 3'd3,
    OP_RXPUSH = 3'd4
  } pbb_op_e;

  // Event strobe bundle.
  typedef struct packed {
    logic tx_under;
    logic tx_under_clr;
    logic tx_ready;
    logic tx_ready_clr;
    logic rx_over;
    logic rx_over_clr;
    logic rx_ready;
    logic rx_single;
  } pbb_evt_t;

endpackage

// File: rtl/pbb_arbiter.sv
module pbb_arbiter
  import pbb_pkg::*;
(
  input  logic    wr_en,
  input  logic    rd_en,
  input  logic    tx_req,
  input  logic    rx_push,
  output pbb_op_e op
);
  // Fixed ranking: write, read, transmit pop, receive push.
  always_comb begin
    if (wr_en)        op = OP_WR;
    else if (rd_en)   op = OP_RD;
    else if (tx_req)  op = OP_TXPOP;
    else if (rx_push) op = OP_RXPUSH;
    else              op = OP_IDLE;
  end
endmodule

// File: rtl/pbb_tx_side.sv
module pbb_tx_side #(
  parameter int BYTE_W = 8,
  parameter int LANES  = 4,
  localparam int WORD_W = BYTE_W * LANES,
  localparam int PAIR_W = 2 * BYTE_W,
  localparam int CNT_W  = $clog2(LANES + 1)
) (
  input  logic [WORD_W-1:0] word,
  input  logic [CNT_W-1:0]  count,
  input  logic              big_endian,
  input  logic [PAIR_W-1:0] wr_data,
  output logic              wr_accept,
  output logic [WORD_W-1:0] wr_word,
  output logic [CNT_W-1:0]  wr_count,
  output logic              wr_ready_clr,
  output logic [BYTE_W-1:0] pop_byte,
  output logic              pop_empty,
  output logic [CNT_W-1:0]  pop_count
);
  localparam logic [CNT_W-1:0] ROOM_LIMIT = CNT_W'(LANES - 2);
  localparam logic [CNT_W-1:0] TWO        = CNT_W'(2);

  // Register pair to low two lanes.
  function automatic logic [PAIR_W-1:0] order_in(input logic be, input logic [PAIR_W-1:0] v);
    if (be) return v;
    return {v[BYTE_W-1:0], v[PAIR_W-1:BYTE_W]};
  endfunction

  function automatic logic [BYTE_W-1:0] lane_of(input logic [WORD_W-1:0] w, input int idx);
    return w[idx*BYTE_W +: BYTE_W];
  endfunction

  assign wr_accept    = (count <= ROOM_LIMIT);
  assign wr_word      = {word[WORD_W-PAIR_W-1:0], order_in(big_endian, wr_data)};
  assign wr_count     = count + TWO;
  assign wr_ready_clr = wr_accept && (wr_count > TWO);

  assign pop_empty = (count == '0);
  assign pop_count = pop_empty ? count : count - CNT_W'(1);
  assign pop_byte  = pop_empty ? '0 : lane_of(word, int'(pop_count));
endmodule

// File: rtl/pbb_rx_side.sv
module pbb_rx_side #(
  parameter int BYTE_W = 8,
  parameter int LANES  = 4,
  localparam int WORD_W = BYTE_W * LANES,
  localparam int PAIR_W = 2 * BYTE_W,
  localparam int CNT_W  = $clog2(LANES + 1)
) (
  input  logic [WORD_W-1:0] word,
  input  logic [CNT_W-1:0]  count,
  input  logic              big_endian,
  input  logic [BYTE_W-1:0] rx_byte,
  output logic              push_full,
  output logic [WORD_W-1:0] push_word,
  output logic [CNT_W-1:0]  push_count,
  output logic [PAIR_W-1:0] rd_data,
  output logic              rd_single,
  output logic [WORD_W-1:0] rd_word,
  output logic [CNT_W-1:0]  rd_count
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(LANES);
  localparam logic [CNT_W-1:0] TWO  = CNT_W'(2);

  // Low two lanes to register pair.
  function automatic logic [PAIR_W-1:0] order_out(input logic be, input logic [PAIR_W-1:0] v);
    if (be) return {v[BYTE_W-1:0], v[PAIR_W-1:BYTE_W]};
    return v;
  endfunction

  function automatic logic [WORD_W-1:0] lane_or(input logic [WORD_W-1:0] w,
                                                 input logic [BYTE_W-1:0] b, input int idx);
    logic [WORD_W-1:0] r;
    r = w;
    r[idx*BYTE_W +: BYTE_W] = w[idx*BYTE_W +: BYTE_W] | b;
    return r;
  endfunction

  assign push_full  = (count == FULL);
  assign push_word  = push_full ? word : lane_or(word, rx_byte, int'(count));
  assign push_count = push_full ? count : count + CNT_W'(1);

  assign rd_data   = order_out(big_endian, word[PAIR_W-1:0]);
  assign rd_single = (count == CNT_W'(1));

  always_comb begin
    rd_word  = word;
    rd_count = count;
    if (rd_single) begin
      rd_count = '0;
    end else if (count >= TWO) begin
      if (count > TWO) rd_word = {{PAIR_W{1'b0}}, word[WORD_W-1:PAIR_W]};
      rd_count = count - TWO;
    end
  end
endmodule

// File: rtl/pbb_buffer.sv
module pbb_buffer
  import pbb_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int LANES  = 4,
  localparam int WORD_W = BYTE_W * LANES,
  localparam int PAIR_W = 2 * BYTE_W,
  localparam int CNT_W  = $clog2(LANES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              big_endian,
  input  logic              wr_en,
  input  logic [PAIR_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [PAIR_W-1:0] rd_data,
  input  logic              tx_req,
  output logic [BYTE_W-1:0] tx_byte,
  input  logic              rx_push,
  input  logic [BYTE_W-1:0] rx_byte,
  output logic [CNT_W-1:0]  tx_count,
  output logic [CNT_W-1:0]  rx_count,
  output logic              ev_tx_under,
  output logic              ev_tx_under_clr,
  output logic              ev_tx_ready,
  output logic              ev_tx_ready_clr,
  output logic              ev_rx_over,
  output logic              ev_rx_over_clr,
  output logic              ev_rx_ready,
  output logic              ev_rx_single
);
  logic [WORD_W-1:0] word_q, word_d;
  logic [CNT_W-1:0]  txc_q, txc_d, rxc_q, rxc_d;
  pbb_op_e           op;
  pbb_evt_t          evt;

  logic              wr_accept, wr_ready_clr, pop_empty, push_full, rd_single;
  logic [WORD_W-1:0] wr_word, push_word, rd_word;
  logic [CNT_W-1:0]  wr_count, pop_count, push_count, rd_count;

  pbb_arbiter u_arb (
    .wr_en(wr_en), .rd_en(rd_en), .tx_req(tx_req), .rx_push(rx_push), .op(op)
  );

  pbb_tx_side #(.BYTE_W(BYTE_W), .LANES(LANES)) u_tx (
    .word(word_q), .count(txc_q), .big_endian(big_endian), .wr_data(wr_data),
    .wr_accept(wr_accept), .wr_word(wr_word), .wr_count(wr_count),
    .wr_ready_clr(wr_ready_clr), .pop_byte(tx_byte), .pop_empty(pop_empty),
    .pop_count(pop_count)
  );

  pbb_rx_side #(.BYTE_W(BYTE_W), .LANES(LANES)) u_rx (
    .word(word_q), .count(rxc_q), .big_endian(big_endian), .rx_byte(rx_byte),
    .push_full(push_full), .push_word(push_word), .push_count(push_count),
    .rd_data(rd_data), .rd_single(rd_single), .rd_word(rd_word), .rd_count(rd_count)
  );

  // Next-state and event selection by granted operation.
  always_comb begin
    word_d = word_q;
    txc_d  = txc_q;
    rxc_d  = rxc_q;
    evt    = '0;
    unique case (op)
      OP_WR: if (wr_accept) begin
        word_d           = wr_word;
        txc_d            = wr_count;
        evt.tx_under_clr = 1'b1;
        evt.tx_ready_clr = wr_ready_clr;
      end
      OP_RD: begin
        word_d          = rd_word;
        rxc_d           = rd_count;
        evt.rx_over_clr = 1'b1;
        evt.rx_single   = rd_single;
      end
      OP_TXPOP: begin
        txc_d        = pop_count;
        evt.tx_under = pop_empty;
        evt.tx_ready = 1'b1;
      end
      OP_RXPUSH: begin
        word_d       = push_word;
        rxc_d        = push_count;
        evt.rx_over  = push_full;
        evt.rx_ready = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      txc_q  <= '0;
      rxc_q  <= '0;
    end else begin
      word_q <= word_d;
      txc_q  <= txc_d;
      rxc_q  <= rxc_d;
    end
  end

  assign tx_count        = txc_q;
  assign rx_count        = rxc_q;
  assign ev_tx_under     = evt.tx_under;
  assign ev_tx_under_clr = evt.tx_under_clr;
  assign ev_tx_ready     = evt.tx_ready;
  assign ev_tx_ready_clr = evt.tx_ready_clr;
  assign ev_rx_over      = evt.rx_over;
  assign ev_rx_over_clr  = evt.rx_over_clr;
  assign ev_rx_ready     = evt.rx_ready;
  assign ev_rx_single    = evt.rx_single;
endmodule

// File: rtl/pbb_checker.sv
module pbb_checker
  import pbb_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int LANES  = 4,
  localparam int CNT_W = $clog2(LANES + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              rd_en,
  input pbb_op_e           op,
  input logic [CNT_W-1:0]  tx_count,
  input logic [CNT_W-1:0]  rx_count,
  input logic [BYTE_W-1:0] tx_byte,
  input logic              ev_tx_under,
  input logic              ev_rx_over_clr,
  input logic              ev_rx_single
);
  localparam logic [CNT_W-1:0] LIM  = CNT_W'(LANES - 2);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(LANES);

  assert_count_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_count <= FULL) && (rx_count <= FULL));

  assert_write_adds_two_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_WR && tx_count <= LIM) |=> tx_count == $past(tx_count) + CNT_W'(2));

  assert_write_refused_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_WR && tx_count > LIM) |=> ($stable(tx_count) && $stable(rx_count)));

  assert_no_underflow_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_TXPOP && tx_count == '0) |-> (ev_tx_under && tx_byte == '0));

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_RXPUSH && rx_count == FULL) |=> rx_count == FULL);

  assert_single_byte_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_RD && rx_count == CNT_W'(1)) |-> ev_rx_single);

  assert_single_empties_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_RD && rx_count == CNT_W'(1)) |=> rx_count == '0);

  assert_read_clears_over_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_RD) |-> ev_rx_over_clr);

  assert_write_masks_read_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && rd_en) |=> $stable(rx_count));
endmodule

bind pbb_buffer pbb_checker #(.BYTE_W(BYTE_W), .LANES(LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .op(op),
  .tx_count(tx_count), .rx_count(rx_count), .tx_byte(tx_byte),
  .ev_tx_under(ev_tx_under), .ev_rx_over_clr(ev_rx_over_clr),
  .ev_rx_single(ev_rx_single)
);

// File: tb/pbb_buffer_tb.sv
module pbb_buffer_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic big_endian = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0, tx_req = 1'b0, rx_push = 1'b0;
  logic [15:0] wr_data = '0;
  logic [7:0]  rx_byte = '0;
  logic [15:0] rd_data;
  logic [7:0]  tx_byte;
  logic [2:0]  tx_count, rx_count;
  logic ev_tx_under, ev_tx_under_clr, ev_tx_ready, ev_tx_ready_clr;
  logic ev_rx_over, ev_rx_over_clr, ev_rx_ready, ev_rx_single;

  int n_checks = 0;
  int n_fail   = 0;

  // Bench model.
  logic [31:0] m_word;
  int          m_tx, m_rx;

  always #5 clk = ~clk;

  pbb_buffer u_dut (
    .clk(clk), .rst_n(rst_n), .big_endian(big_endian),
    .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
    .tx_req(tx_req), .tx_byte(tx_byte), .rx_push(rx_push), .rx_byte(rx_byte),
    .tx_count(tx_count), .rx_count(rx_count),
    .ev_tx_under(ev_tx_under), .ev_tx_under_clr(ev_tx_under_clr),
    .ev_tx_ready(ev_tx_ready), .ev_tx_ready_clr(ev_tx_ready_clr),
    .ev_rx_over(ev_rx_over), .ev_rx_over_clr(ev_rx_over_clr),
    .ev_rx_ready(ev_rx_ready), .ev_rx_single(ev_rx_single)
  );

  task automatic check(input string req, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] lane(input logic [31:0] w, input int k);
    return 8'((w >> (8 * k)) & 32'hff);
  endfunction

  // Read view: big-endian swaps the low pair, little leaves it.
  function automatic logic [15:0] read_view(input logic be, input logic [31:0] w);
    return be ? {lane(w, 0), lane(w, 1)} : {lane(w, 1), lane(w, 0)};
  endfunction

  function automatic logic [15:0] write_pair(input logic be, input logic [15:0] v);
    return be ? v : {v[7:0], v[15:8]};
  endfunction

  function automatic logic [7:0] offer(input logic [31:0] w, input int c);
    return (c == 0) ? 8'h00 : lane(w, c - 1);
  endfunction

  // One cycle with a strobe mask {wr, rd, tx, rx}.
  task automatic step(input logic [3:0] mask, input logic be, input logic [15:0] d,
                      input logic [7:0] b, input string tag);
    logic [7:0] exp_ev;
    logic [7:0] act_ev;
    logic [7:0] exp_tx;
    exp_ev = '0;
    @(negedge clk);
    big_endian = be; wr_data = d; rx_byte = b;
    {wr_en, rd_en, tx_req, rx_push} = mask;
    #1;
    check({tag, " R9 rd_data"}, rd_data, read_view(be, m_word));
    exp_tx = offer(m_word, m_tx);
    check({tag, " R5 tx_byte"}, tx_byte, exp_tx);
    // bit order: tx_under, tx_under_clr, tx_ready, tx_ready_clr, rx_over, rx_over_clr, rx_ready, rx_single
    if (mask[3]) begin
      if (m_tx <= 2) begin
        m_word = {m_word[15:0], write_pair(be, d)};
        m_tx += 2;
        exp_ev[6] = 1'b1;
        exp_ev[4] = (m_tx > 2);
      end
    end else if (mask[2]) begin
      exp_ev[2] = 1'b1;
      if (m_rx == 1) begin
        exp_ev[0] = 1'b1; m_rx = 0;
      end else if (m_rx >= 2) begin
        if (m_rx > 2) m_word = m_word >> 16;
        m_rx -= 2;
      end
    end else if (mask[1]) begin
      exp_ev[5] = 1'b1;
      if (m_tx == 0) exp_ev[7] = 1'b1;
      else m_tx -= 1;
    end else if (mask[0]) begin
      exp_ev[1] = 1'b1;
      if (m_rx == 4) exp_ev[3] = 1'b1;
      else begin
        m_word = m_word | (32'(b) << (8 * m_rx));
        m_rx += 1;
      end
    end
    act_ev = {ev_tx_under, ev_tx_under_clr, ev_tx_ready, ev_tx_ready_clr,
              ev_rx_over, ev_rx_over_clr, ev_rx_ready, ev_rx_single};
    check({tag, " R13 events"}, act_ev, exp_ev);
    @(negedge clk);
    {wr_en, rd_en, tx_req, rx_push} = 4'b0000;
    #1;
    check({tag, " R2 tx_count"}, tx_count, m_tx);
    check({tag, " R7 rx_count"}, rx_count, m_rx);
    check({tag, " R11 word view"}, rd_data, read_view(be, m_word));
    check({tag, " R5 next offer"}, tx_byte, offer(m_word, m_tx));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    m_word = '0; m_tx = 0; m_rx = 0;
    repeat (3) @(negedge clk);
    #1;
    check("R1 reset tx_count", tx_count, 0);
    check("R1 reset rx_count", rx_count, 0);
    check("R1 reset rd_data", rd_data, 0);
    check("R1 reset tx_byte", tx_byte, 0);
    rst_n = 1'b1;

    // R6: pop while empty.
    step(4'b0010, 1'b0, 16'h0, 8'h0, "R6 empty pop");
    // R4 little order and R3 refusal.
    step(4'b1000, 1'b0, 16'hA1B2, 8'h0, "R4 le write");
    step(4'b1000, 1'b1, 16'hC3D4, 8'h0, "R4 be write");
    step(4'b1000, 1'b1, 16'hFFFF, 8'h0, "R3 refused write");
    for (int i = 0; i < 5; i++) step(4'b0010, 1'b0, 16'h0, 8'h0, "R5 drain");
    // R7/R8: fill receive side past full.
    for (int i = 0; i < 5; i++) step(4'b0001, 1'b0, 16'h0, 8'(8'h11 * (i + 1)), "R8 fill");
    step(4'b0100, 1'b1, 16'h0, 8'h0, "R11 read of four");
    step(4'b0001, 1'b0, 16'h0, 8'h0F, "R7 push");
    step(4'b0100, 1'b0, 16'h0, 8'h0, "R11 read of three");
    step(4'b0100, 1'b0, 16'h0, 8'h0, "R10 single read");
    step(4'b0100, 1'b0, 16'h0, 8'h0, "R12 empty read");
    // R13 priority mixes.
    step(4'b1111, 1'b0, 16'h1234, 8'h55, "R13 all strobes");
    step(4'b0111, 1'b1, 16'h0, 8'h66, "R13 read over pops");
    step(4'b0011, 1'b0, 16'h0, 8'h77, "R13 pop over push");

    for (int i = 0; i < 3000; i++) begin
      logic [3:0] m;
      m = 4'($urandom_range(0, 15));
      if ($urandom_range(0, 3) != 0) m = 4'b0001 << $urandom_range(0, 3);
      step(m, 1'($urandom_range(0, 1)), 16'($urandom), 8'($urandom), "random");
    end

    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule